// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A synchronous single-port static memory with a pipelined command interface in which reads and writes may follow each other on consecutive clock edges with no idle cycle between them. On every rising edge the block samples three chip enables, an advance/load strobe, a read/write select, four active-low byte-lane strobes, an active-low clock enable and a sleep input. It decodes them into deselect, burst begin, burst continue, dummy read, write abort, stall and sleep operations. A two-bit burst counter walks through an aligned group of four words in linear or interleaved order. The burst type is the one chosen when the burst began.

Both data phases run two enabled edges behind their address. Read data is driven onto the bus in the cycle that ends at the second enabled edge after the address edge. Write data is captured at that same second edge. Because both phases share this slot, the bus never needs a turnaround gap. The bidirectional data bus is modelled as an input word, an output word and an output-enable flag. A command decoder state machine tracks the last operation type: `ST_DESEL` (deselected), `ST_RD` (read burst), `ST_WR` (write burst) and `ST_SLEEP`. Its transitions are as follows:
- Begin-with-select goes to `ST_RD` or `ST_WR`.
- Begin-without-select goes to `ST_DESEL`.
- Continue from `ST_RD` or `ST_WR` stays in that state.
- Continue from `ST_DESEL` stays in `ST_DESEL`.
- Continue from `ST_SLEEP` goes to `ST_DESEL`.
- A sleep edge goes to `ST_SLEEP` from any state.
- A stall edge keeps the current state.

Top module: `zt_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, the pipeline holds no operation and `dq_oe` is 0 until a read reaches its data phase.
- R2: With `adv_ld`=0, a burst begins only when `en0_n`=0, `en1`=1 and `en2_n`=0. Any other enable combination is a deselect, no operation enters the pipeline, and `dq_oe` stays 0 for the slot that edge owns.
- R3: A read whose address is sampled on enabled edge n drives `mem[addr]` on `dq_out` with `dq_oe`=1 (when `oe_n`=0) from just after enabled edge n+1 until enabled edge n+2. `rd_wr`=1 selects read.
- R4: A write (`rd_wr`=0) whose address is sampled on enabled edge n takes `dq_in` at enabled edge n+2. Byte lane i is bits [9i+8:9i]; it is written only when `bw_n[i]`=0 at the address edge.
- R5: A write with `bw_n`=4'b1111 is a write abort and leaves every word unchanged.
- R6: A read with `oe_n`=1 during its data phase is a dummy read: `dq_oe` stays 0 and memory is unchanged.
- R7: With `adv_ld`=1 after a begun burst, the operation type is kept and `en*` and `rd_wr` are ignored. The k-th continue uses address bits [1:0] = (base+k) mod 4 when `mode_il`=0, or base XOR k when `mode_il`=1, with the upper address bits fixed. A write continue uses the `bw_n` of its own edge.
- R8: With `adv_ld`=1 after a deselect or a sleep, the block stays deselected and `dq_oe` stays 0 for that slot.
- R9: During a write data phase `dq_oe` is 0 whatever `oe_n` is. Reads and writes issued on consecutive edges each complete with no idle cycle.
- R10: With `cen_n`=1 (and `sleep`=0), the edge is ignored: no state, counter or pipeline change, no memory write, and `dq_out`/`dq_oe` hold.
- R11: With `sleep`=1, `dq_oe` is 0 at once regardless of other inputs. The edge flushes the pipeline without writing, and sleep takes priority over `cen_n`.
- R12: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old contents of unwritten lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline and decoder |
| cen_n | input | 1 | Active-low clock enable; high ignores the edge |
| sleep | input | 1 | Sleep request, overrides all other inputs |
| en0_n | input | 1 | Active-low chip enable |
| en1 | input | 1 | Active-high chip enable |
| en2_n | input | 1 | Second active-low chip enable |
| adv_ld | input | 1 | 0 loads an external address, 1 continues the burst |
| rd_wr | input | 1 | 1 read, 0 write, sampled at burst begin |
| bw_n | input | LANES | Active-low byte-lane write strobes |
| oe_n | input | 1 | Active-low output enable |
| mode_il | input | 1 | 1 interleaved burst order, 0 linear |
| addr | input | ADDR_W | External word address |
| dq_in | input | DATA_W | Write data (bus input side) |
| dq_out | output | DATA_W | Read data (bus output side) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bound checker checks on every cycle that sleep and write data phases keep the bus off, and that a stalled edge holds the read data. It also checks that a deselect, and a continue that follows one, leave their slot undriven, that a selected read drives its slot two enabled edges later, and that the bus is quiet on the first edge after reset. What only the bench scenarios can show is the data itself. This covers burst address order in both modes, per-lane merging, write aborts, dummy reads, the same-address read-after-write bypass, and the absence of writes on stalled or sleeping edges. A cycle-accurate reference model compares these against the ports on every clock, over directed and randomised command streams.

// File: rtl/zt_pkg.sv
package zt_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_SLEEP = 2'd3
    } zt_state_e;

    // low two address bits of burst step k from the loaded base
    function automatic logic [1:0] zt_burst_low(input logic [1:0] base,
                                                input logic [1:0] k,
                                                input logic       il);
        return il ? (base ^ k) : (base + k);
    endfunction

endpackage

// File: rtl/zt_lane_mem.sv
module zt_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [LANES-1:0]          wbw_n,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANE_W*LANES-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANE_W*LANES-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wbw_n[i]) begin
                arr[waddr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = arr[raddr];
    end

endmodule

// File: rtl/zt_cmd_fsm.sv
module zt_cmd_fsm
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sleep,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic [LANES-1:0]  bw_n,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] addr,
    output logic              op_vld,
    output logic              op_wr,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_bw_n
);
    zt_state_e         state, nstate;
    logic [1:0]        cnt;
    logic [1:0]        cnt_next;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] cont_addr;

    assign cnt_next  = cnt + 2'd1;
    assign cont_addr = {base[ADDR_W-1:2], zt_burst_low(base[1:0], cnt_next, mode_il)};

    // next-state decode
    always_comb begin
        nstate = state;
        if (sleep) begin
            nstate = ST_SLEEP;
        end else if (step) begin
            if (!adv_ld) begin
                if (sel) nstate = rd_wr ? ST_RD : ST_WR;
                else     nstate = ST_DESEL;
            end else if (state == ST_SLEEP) begin
                nstate = ST_DESEL;
            end
        end
    end

    // state register plus burst base and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DESEL;
            cnt   <= 2'd0;
            base  <= '0;
        end else begin
            state <= nstate;
            if (step && !sleep) begin
                if (!adv_ld) begin
                    base <= addr;
                    cnt  <= 2'd0;
                end else if (state == ST_RD || state == ST_WR) begin
                    cnt <= cnt_next;
                end
            end
        end
    end

    // issued operation for this edge
    always_comb begin
        op_vld  = 1'b0;
        op_wr   = 1'b0;
        op_addr = addr;
        op_bw_n = bw_n;
        if (!adv_ld) begin
            op_vld = sel;
            op_wr  = !rd_wr;
        end else begin
            unique case (state)
                ST_RD: begin
                    op_vld  = 1'b1;
                    op_addr = cont_addr;
                end
                ST_WR: begin
                    op_vld  = 1'b1;
                    op_wr   = 1'b1;
                    op_addr = cont_addr;
                end
                ST_DESEL, ST_SLEEP: begin
                    op_vld = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/zt_pipe.sv
module zt_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     sleep,
    input  logic                     op_vld,
    input  logic                     op_wr,
    input  logic [ADDR_W-1:0]        op_addr,
    input  logic [LANES-1:0]         op_bw_n,
    input  logic [LANE_W*LANES-1:0]  dq_in,
    input  logic [LANE_W*LANES-1:0]  mem_rdata,
    output logic                     mem_we,
    output logic [LANES-1:0]         mem_bw_n,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [ADDR_W-1:0]        mem_raddr,
    output logic [LANE_W*LANES-1:0]  dq_out,
    output logic                     rd_drive,
    output logic                     wr_phase
);
    localparam int DATA_W = LANE_W * LANES;

    logic              s1_vld, s1_wr, s2_vld, s2_wr;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_bw_n, s2_bw_n;
    logic              hit;
    logic [DATA_W-1:0] fwd;

    assign wr_phase  = s2_vld && s2_wr;
    assign mem_we    = step && wr_phase;
    assign mem_bw_n  = s2_bw_n;
    assign mem_waddr = s2_addr;
    assign mem_raddr = s1_addr;
    assign hit       = wr_phase && (s2_addr == s1_addr);

    // bypass lanes being written on the same edge the read samples
    for (genvar i = 0; i < LANES; i++) begin : g_fwd
        assign fwd[i*LANE_W +: LANE_W] = (hit && !s2_bw_n[i]) ?
            dq_in[i*LANE_W +: LANE_W] : mem_rdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_bw_n  <= '1;
            s2_vld   <= 1'b0;
            s2_wr    <= 1'b0;
            s2_addr  <= '0;
            s2_bw_n  <= '1;
            rd_drive <= 1'b0;
            dq_out   <= '0;
        end else if (sleep) begin
            s1_vld   <= 1'b0;
            s2_vld   <= 1'b0;
            rd_drive <= 1'b0;
        end else if (step) begin
            s1_vld   <= op_vld;
            s1_wr    <= op_wr;
            s1_addr  <= op_addr;
            s1_bw_n  <= op_bw_n;
            s2_vld   <= s1_vld;
            s2_wr    <= s1_wr;
            s2_addr  <= s1_addr;
            s2_bw_n  <= s1_bw_n;
            rd_drive <= s1_vld && !s1_wr;
            if (s1_vld && !s1_wr) begin
                dq_out <= fwd;
            end
        end
    end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              sleep,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              mode_il,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              step, sel;
    logic              op_vld, op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_bw_n;
    logic              mem_we;
    logic [LANES-1:0]  mem_bw_n;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              rd_drive;
    logic              wr_phase;

    assign step  = !cen_n && !sleep;
    assign sel   = !en0_n && en1 && !en2_n;
    assign dq_oe = rd_drive && !oe_n && !sleep;

    zt_cmd_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .sleep   (sleep),
        .sel     (sel),
        .adv_ld  (adv_ld),
        .rd_wr   (rd_wr),
        .bw_n    (bw_n),
        .mode_il (mode_il),
        .addr    (addr),
        .op_vld  (op_vld),
        .op_wr   (op_wr),
        .op_addr (op_addr),
        .op_bw_n (op_bw_n)
    );

    zt_pipe #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sleep     (sleep),
        .op_vld    (op_vld),
        .op_wr     (op_wr),
        .op_addr   (op_addr),
        .op_bw_n   (op_bw_n),
        .dq_in     (dq_in),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_bw_n  (mem_bw_n),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .dq_out    (dq_out),
        .rd_drive  (rd_drive),
        .wr_phase  (wr_phase)
    );

    zt_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wbw_n (mem_bw_n),
        .waddr (mem_waddr),
        .wdata (dq_in),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              sleep,
    input logic              en0_n,
    input logic              en1,
    input logic              en2_n,
    input logic              adv_ld,
    input logic              rd_wr,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              wr_phase
);
    logic step_c, sel_c;
    assign step_c = !cen_n && !sleep;
    assign sel_c  = !en0_n && en1 && !en2_n;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe);  // R1

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && !adv_ld && !sel_c) ##1 step_c |=> !dq_oe);  // R2

    AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && !adv_ld && sel_c && rd_wr) ##1 step_c |=> (sleep || oe_n || dq_oe));  // R3

    AST_CONT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && !adv_ld && !sel_c) ##1 (step_c && adv_ld) ##1 step_c |=> !dq_oe);  // R8

    AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |-> !dq_oe);  // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n && !sleep) |=> $stable(dq_out));  // R10

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);  // R11

endmodule

bind zt_burst_sram zt_burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .sleep    (sleep),
    .en0_n    (en0_n),
    .en1      (en1),
    .en2_n    (en2_n),
    .adv_ld   (adv_ld),
    .rd_wr    (rd_wr),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .wr_phase (wr_phase)
);

// File: tb/test_zt_burst_sram.sv
`timescale 1ns/1ps
module test_zt_burst_sram;
    localparam int AW = 6;
    localparam int LW = 9;
    localparam int NL = 4;
    localparam int DW = LW * NL;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0, sleep = 1'b0;
    logic          en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b1;
    logic          adv_ld = 1'b0, rd_wr = 1'b1, oe_n = 1'b0, mode_il = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #2 clk = ~clk;  // 250 MHz

    zt_burst_sram i_zt_burst_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .adv_ld(adv_ld),
        .rd_wr(rd_wr), .bw_n(bw_n), .oe_n(oe_n), .mode_il(mode_il),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [NL-1:0] bw;
        logic [AW-1:0] a;
    } mop_t;

    mop_t          pq[$];
    logic [DW-1:0] mm [WORDS];
    int            mst;     // 0 deselected, 1 read burst, 2 write burst, 3 sleeping
    int            mbase, mcnt;
    logic          exp_drv;
    logic [DW-1:0] exp_dout;

    always @(posedge clk) begin
        mop_t oldop, midop, nop;
        nop = '0;
        if (!rst_n) begin
            pq.delete(); pq.push_back('0); pq.push_back('0);
            mst = 0; mbase = 0; mcnt = 0; exp_drv = 1'b0; exp_dout = '0;
        end else if (sleep) begin
            pq.delete(); pq.push_back('0); pq.push_back('0);
            exp_drv = 1'b0; mst = 3;
        end else if (!cen_n) begin
            oldop = pq[0];
            midop = pq[1];
            if (oldop.vld && oldop.wr)
                for (int i = 0; i < NL; i++)
                    if (!oldop.bw[i]) mm[oldop.a][i*LW +: LW] = dq_in[i*LW +: LW];
            exp_drv = midop.vld && !midop.wr;
            if (exp_drv) exp_dout = mm[midop.a];
            if (!adv_ld) begin
                if (!en0_n && en1 && !en2_n) begin
                    nop.vld = 1'b1; nop.wr = !rd_wr; nop.bw = bw_n; nop.a = addr;
                    mbase = int'(addr); mcnt = 0; mst = rd_wr ? 1 : 2;
                end else begin
                    mst = 0;
                end
            end else if (mst == 1 || mst == 2) begin
                int low;
                mcnt = (mcnt + 1) % 4;
                low  = mode_il ? ((mbase % 4) ^ mcnt) : (((mbase % 4) + mcnt) % 4);
                nop.vld = 1'b1; nop.wr = (mst == 2); nop.bw = bw_n;
                nop.a = AW'((mbase / 4) * 4 + low);
            end else begin
                mst = 0;
            end
            void'(pq.pop_front());
            pq.push_back(nop);
        end
    end

    // ---------------- checking ----------------
    int    checks = 0, errors = 0;
    string cur_req = "R1";

    always @(negedge clk) begin
        logic exp_oe;
        #1;
        exp_oe = rst_n ? (exp_drv && !oe_n && !sleep) : 1'b0;
        checks++;
        if (dq_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s dq_oe actual %0b expected %0b at %0t", cur_req, dq_oe, exp_oe, $time);
        end
        if (exp_oe) begin
            checks++;
            if (dq_out !== exp_dout) begin
                errors++;
                $display("FAIL %s dq_out actual %h expected %h at %0t", cur_req, dq_out, exp_dout, $time);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drv(input logic c, input logic s, input logic e0, input logic e1,
                       input logic e2, input logic al, input logic rw,
                       input logic [NL-1:0] bw, input logic oe, input logic il,
                       input logic [AW-1:0] a);
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        cen_n = c; sleep = s; en0_n = e0; en1 = e1; en2_n = e2; adv_ld = al;
        rd_wr = rw; bw_n = bw; oe_n = oe; mode_il = il; addr = a; dq_in = r[DW-1:0];
        @(negedge clk);
    endtask

    task automatic begin_op(input logic rw, input logic [AW-1:0] a,
                            input logic [NL-1:0] bw, input logic oe, input logic il);
        drv(0, 0, 0, 1, 0, 0, rw, bw, oe, il, a);
    endtask

    // enables and rd_wr set to deselect/opposite values to show they are ignored
    task automatic cont(input logic [NL-1:0] bw, input logic oe, input logic il);
        drv(0, 0, 1, 0, 1, 1, $urandom_range(0, 1) != 0, bw, oe, il, AW'($urandom));
    endtask

    task automatic desel(input logic oe);
        drv(0, 0, 1, 0, 0, 0, 1, '1, oe, 0, '0);
    endtask

    task automatic stall(input logic oe);
        drv(1, 0, 0, 1, 0, 0, 1, '0, oe, 0, AW'($urandom));
    endtask

    task automatic nap(input logic c);
        drv(c, 1, 0, 1, 0, 0, 0, '0, 0, 0, AW'($urandom));
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) desel(0);
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        for (int k = 0; k < 4; k++) desel(0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) desel(0);

        cur_req = "R4";  // fill every word, full lanes
        for (int a = 0; a < WORDS; a++) begin_op(0, AW'(a), '0, 0, 0);
        flush();

        cur_req = "R3";  // single reads, back to back
        for (int a = 0; a < WORDS; a += 3) begin_op(1, AW'(a), '1, 0, 0);
        flush();

        cur_req = "R2";  // every non-selecting enable combination
        for (int m = 0; m < 8; m++) begin
            if (m != 3'b010) drv(0, 0, m[2], m[1], m[0], 0, 1, '1, 0, 0, AW'(m));
        end
        flush();

        cur_req = "R7";  // linear and interleaved bursts
        begin_op(1, 6'd5, '1, 0, 0); cont('1, 0, 0); cont('1, 0, 0); cont('1, 0, 0);
        begin_op(1, 6'd14, '1, 0, 1); cont('1, 0, 1); cont('1, 0, 1); cont('1, 0, 1);
        begin_op(0, 6'd21, 4'b0000, 0, 1); cont(4'b0101, 0, 1); cont(4'b1010, 0, 1); cont(4'b0000, 0, 1);
        begin_op(1, 6'd20, '1, 0, 0); cont('1, 0, 0); cont('1, 0, 0); cont('1, 0, 0);
        cont('1, 0, 0);  // counter wraps inside the group
        flush();

        cur_req = "R5";  // write abort then read back
        begin_op(0, 6'd2, 4'b1111, 0, 0); begin_op(0, 6'd3, 4'b1111, 0, 0);
        begin_op(1, 6'd2, '1, 0, 0); begin_op(1, 6'd3, '1, 0, 0);
        flush();

        cur_req = "R6";  // dummy read keeps bus off
        begin_op(1, 6'd7, '1, 1, 0); desel(1); desel(1);
        begin_op(1, 6'd7, '1, 0, 0);
        flush();

        cur_req = "R8";  // continue after deselect, with enables selecting
        desel(0);
        drv(0, 0, 0, 1, 0, 1, 1, '0, 0, 0, 6'd9);
        drv(0, 0, 0, 1, 0, 1, 0, '0, 0, 0, 6'd9);
        flush();

        cur_req = "R9";  // alternating read/write, oe held low
        for (int k = 0; k < 16; k++) begin_op(k[0], AW'(k + 30), 4'b0000, 0, 0);
        flush();

        cur_req = "R12";  // read right after a partial write to same address
        begin_op(0, 6'd40, 4'b0110, 0, 0); begin_op(1, 6'd40, '1, 0, 0);
        begin_op(0, 6'd41, 4'b0000, 0, 0); begin_op(1, 6'd41, '1, 0, 0);
        flush();

        cur_req = "R10";  // stalls inside read and write streams
        begin_op(1, 6'd11, '1, 0, 0); stall(0); begin_op(1, 6'd12, '1, 0, 0);
        stall(0); stall(1); stall(0);
        begin_op(0, 6'd13, 4'b0000, 0, 0); stall(0); desel(0); stall(0); stall(0);
        desel(0); begin_op(1, 6'd13, '1, 0, 0);
        flush();

        cur_req = "R11";  // sleep mid-flow, and sleep with clock enable high
        begin_op(1, 6'd15, '1, 0, 0); begin_op(0, 6'd16, 4'b0000, 0, 0);
        nap(0); nap(1); cont('1, 0, 0); desel(0);
        begin_op(1, 6'd16, '1, 0, 0); begin_op(1, 6'd15, '1, 0, 0);
        flush();

        cur_req = "R9";  // randomized command stream
        for (int k = 0; k < 3000; k++) begin
            int sel_k;
            sel_k = $urandom_range(0, 31);
            if (sel_k < 3) stall($urandom_range(0, 7) == 0);
            else if (sel_k == 3) nap($urandom_range(0, 1) != 0);
            else if (sel_k < 7) desel(0);
            else if (sel_k < 20)
                begin_op($urandom_range(0, 1) != 0, AW'($urandom),
                         ($urandom_range(0, 3) == 0) ? 4'b1111 : NL'($urandom),
                         $urandom_range(0, 7) == 0, $urandom_range(0, 1) != 0);
            else cont(NL'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 1) != 0);
        end
        flush();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule